// File: doc/BRIEF.md
# Over-current alarm throttle controller

This block watches a single over-current alarm line coming from outside the chip and turns it into two outputs: a throttle request level and a one-cycle interrupt pulse. The alarm line is brought into the clock domain through a synchronizer. It is then interpreted as active high or active low, and every change from inactive to active becomes one discrete alarm event. Events are counted. Once enough of them have arrived, and interrupts are enabled, the block pulses its interrupt output and starts counting again from zero.

Two timers shape the behaviour. An inactivity filter clears the event count when the alarms stop arriving for a programmed number of clock cycles. A hold timer, ticking in microseconds, keeps the throttle request asserted for a programmed time after the alarm line returns to inactive. All settings are written through a small write-only register port. Choosing among several throttle sources and actually slowing any clock are left to the logic that consumes `throttle_o`.

Top module: `oc_throttle_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves `throttle_o` and `irq_o` low and clears the event count, the filter timer, the hold timer and all settings (interrupts disabled, active-high polarity, threshold, filter and hold all zero).
- R2: The alarm line passes through a two-flop synchronizer. Each inactive-to-active change of the synchronized line counts as exactly one event, however long the line then stays active.
- R3: Control bit 1 selects polarity: 0 means the alarm is active when the line is high, 1 means active when low. Changing this bit never creates an event by itself. With bit 1 set, a low line holds `throttle_o` high.
- R4: With interrupts enabled, `irq_o` pulses high for exactly one cycle on the event that finds the count already at or above the threshold, that is on event number threshold+1 since the count was last cleared. The count then returns to zero.
- R5: A threshold of zero gives one interrupt pulse for every event.
- R6: Control bit 0 enables interrupts. While it is 0, `irq_o` stays low whatever events arrive.
- R7: Each event reloads the filter timer with the filter value. If the timer then runs down to zero with no new event, the event count is cleared. Events spaced no more than the filter value apart keep accumulating.
- R8: A filter value of zero disables the inactivity clear, so the count survives any length of quiet time.
- R9: `throttle_o` is high while the synchronized alarm is active. After the alarm goes inactive, it stays high for hold × CYC_PER_US more cycles. An isolated alarm pulse of L cycles therefore produces exactly L + hold × CYC_PER_US high cycles of `throttle_o`.
- R10: With a hold value of zero, `throttle_o` follows the synchronized alarm one-for-one, giving L high cycles for an L-cycle pulse.
- R11: A write with `cfg_we` high selects its register by `cfg_addr`: 0 is control (bit 0 interrupt enable, bit 1 polarity), 1 is threshold, 2 is filter in clock cycles, and 3 is hold in microseconds. Each value sits in the low bits of `cfg_wdata` and takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alarm_i | input | 1 | Raw over-current alarm line, asynchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | DATA_W | Write data |
| throttle_o | output | 1 | Throttle request level |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Pulses are sent in several forms: short and long pulses, to show that a held alarm counts only once, and bursts under thresholds of zero and two, to tell every-event interrupts apart from counted ones. Random pulse lengths with gaps kept inside the filter window are checked against gaps far outside it, which separates accumulation from inactivity clearing, and the same wide gaps with the filter at zero show that the clear is really off. Random hold values against measured throttle lengths pin the hold arithmetic to the exact cycle. An active-low run shows that a polarity change alone never counts as an event.

// File: rtl/oc_pkg.sv
package oc_pkg;

  // Register select codes on cfg_addr
  typedef enum logic [1:0] {
    OC_REG_CTRL   = 2'd0,
    OC_REG_THRESH = 2'd1,
    OC_REG_FILTER = 2'd2,
    OC_REG_HOLD   = 2'd3
  } oc_reg_e;

  // Bit positions inside the control register
  localparam int OC_CTRL_IRQ_EN = 0;
  localparam int OC_CTRL_ACT_LO = 1;

endpackage

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
  import oc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int FILT_W = 24,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              irq_en,
  output logic              active_low,
  output logic [CNT_W-1:0]  thresh,
  output logic [FILT_W-1:0] filt_win,
  output logic [HOLD_W-1:0] hold_us
);

  // upper write-data bits are unused for narrow fields
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en     <= 1'b0;
      active_low <= 1'b0;
      thresh     <= '0;
      filt_win   <= '0;
      hold_us    <= '0;
    end else if (we) begin
      case (oc_reg_e'(addr))
        OC_REG_CTRL: begin
          irq_en     <= wdata[OC_CTRL_IRQ_EN];
          active_low <= wdata[OC_CTRL_ACT_LO];
        end
        OC_REG_THRESH: thresh   <= wdata[CNT_W-1:0];
        OC_REG_FILTER: filt_win <= wdata[FILT_W-1:0];
        OC_REG_HOLD:   hold_us  <= wdata[HOLD_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/oc_alarm_front.sv
module oc_alarm_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic alarm_raw,
  input  logic active_low,
  output logic alarm_active,
  output logic alarm_event
);

  // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES]
  // its previous value; both are raw (pre-polarity) bits.
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-1:0], alarm_raw};
  end

  logic lvl_now, lvl_prev;

  // Polarity is applied to both samples with the current setting, so a
  // polarity change alone never looks like an edge.
  assign lvl_now      = chain[SYNC_STAGES-1] ^ active_low;
  assign lvl_prev     = chain[SYNC_STAGES]   ^ active_low;
  assign alarm_active = lvl_now;
  assign alarm_event  = lvl_now & ~lvl_prev;

endmodule

// File: rtl/oc_event_counter.sv
module oc_event_counter #(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alarm_event,
  input  logic              irq_en,
  input  logic [CNT_W-1:0]  thresh,
  input  logic [FILT_W-1:0] filt_win,
  output logic              irq,
  output logic [CNT_W-1:0]  ev_cnt,
  output logic [FILT_W-1:0] filt_cnt
);

  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [FILT_W-1:0] FILT_ONE = FILT_W'(1);

  logic fire;
  assign fire = alarm_event & irq_en & (ev_cnt >= thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      ev_cnt   <= '0;
      filt_cnt <= '0;
    end else begin
      irq <= fire;
      if (alarm_event) begin
        filt_cnt <= filt_win;
        if (fire)                 ev_cnt <= '0;
        else if (ev_cnt != CNT_MAX) ev_cnt <= ev_cnt + CNT_W'(1);
      end else if (filt_cnt != '0) begin
        filt_cnt <= filt_cnt - FILT_ONE;
        if (filt_cnt == FILT_ONE) ev_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/oc_hold_timer.sv
module oc_hold_timer #(
  parameter int HOLD_W     = 16,
  parameter int CYC_PER_US = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alarm_active,
  input  logic [HOLD_W-1:0] hold_us,
  output logic              throttle,
  output logic [HOLD_W-1:0] hold_cnt
);

  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic             us_tick;

  assign us_tick = (pre_cnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      hold_cnt <= '0;
      throttle <= 1'b0;
    end else begin
      throttle <= alarm_active | (hold_cnt != '0);
      if (alarm_active) begin
        hold_cnt <= hold_us;
        pre_cnt  <= '0;
      end else if (hold_cnt != '0) begin
        if (us_tick) begin
          pre_cnt  <= '0;
          hold_cnt <= hold_cnt - HOLD_W'(1);
        end else begin
          pre_cnt  <= pre_cnt + PRE_W'(1);
        end
      end else begin
        pre_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/oc_throttle_ctrl.sv
module oc_throttle_ctrl #(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int FILT_W      = 24,
  parameter int HOLD_W      = 16,
  parameter int CYC_PER_US  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alarm_i,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              throttle_o,
  output logic              irq_o
);

  logic              irq_en;
  logic              active_low;
  logic [CNT_W-1:0]  thresh;
  logic [FILT_W-1:0] filt_win;
  logic [HOLD_W-1:0] hold_us;
  logic              alarm_active;
  logic              alarm_event;
  logic [CNT_W-1:0]  ev_cnt;
  logic [FILT_W-1:0] filt_cnt;
  logic [HOLD_W-1:0] hold_cnt;

  oc_cfg_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .irq_en(irq_en), .active_low(active_low), .thresh(thresh),
    .filt_win(filt_win), .hold_us(hold_us)
  );

  oc_alarm_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .alarm_raw(alarm_i), .active_low(active_low),
    .alarm_active(alarm_active), .alarm_event(alarm_event)
  );

  oc_event_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_count (
    .clk(clk), .rst(rst), .alarm_event(alarm_event), .irq_en(irq_en),
    .thresh(thresh), .filt_win(filt_win), .irq(irq_o),
    .ev_cnt(ev_cnt), .filt_cnt(filt_cnt)
  );

  oc_hold_timer #(.HOLD_W(HOLD_W), .CYC_PER_US(CYC_PER_US)) u_hold (
    .clk(clk), .rst(rst), .alarm_active(alarm_active), .hold_us(hold_us),
    .throttle(throttle_o), .hold_cnt(hold_cnt)
  );

endmodule

// File: rtl/oc_throttle_chk.sv
module oc_throttle_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int FILT_W = 24,
  parameter int HOLD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              throttle_o,
  input logic              irq_o,
  input logic              irq_en,
  input logic [CNT_W-1:0]  thresh,
  input logic [FILT_W-1:0] filt_win,
  input logic              alarm_active,
  input logic              alarm_event,
  input logic [CNT_W-1:0]  ev_cnt,
  input logic [FILT_W-1:0] filt_cnt,
  input logic [HOLD_W-1:0] hold_cnt
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!throttle_o && !irq_o && ev_cnt == '0 && hold_cnt == '0));

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R4
  irq_restart_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ev_cnt == '0);

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_o);

  // R7
  filter_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (filt_cnt == FILT_W'(1) && !alarm_event) |=> ev_cnt == '0);

  // R8
  filter_off_chk: assert property (@(posedge clk) disable iff (rst)
    (filt_win == '0 && filt_cnt == '0 && !alarm_event && !irq_o)
      |=> ev_cnt == $past(ev_cnt));

  // R9
  throttle_on_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_active |=> throttle_o);

  // R9
  throttle_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!alarm_active && hold_cnt == '0) |=> !throttle_o);

  // R11
  thresh_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd1) |=> thresh == $past(cfg_wdata[CNT_W-1:0]));

endmodule

bind oc_throttle_ctrl oc_throttle_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .throttle_o(throttle_o), .irq_o(irq_o),
  .irq_en(irq_en), .thresh(thresh), .filt_win(filt_win),
  .alarm_active(alarm_active), .alarm_event(alarm_event),
  .ev_cnt(ev_cnt), .filt_cnt(filt_cnt), .hold_cnt(hold_cnt)
);

// File: tb/sim_oc_throttle_ctrl.sv
`timescale 1ns/1ps
module sim_oc_throttle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 4;
  localparam int DW         = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alarm_i = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          throttle_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  int irq_seen = 0;
  int thr_seen = 0;
  logic idle_lvl = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_throttle_ctrl #(.DATA_W(DW), .CYC_PER_US(CYC)) u0 (
    .clk(clk), .rst(rst), .alarm_i(alarm_i), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .throttle_o(throttle_o), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (irq_o)      irq_seen++;
      if (throttle_o) thr_seen++;
    end
  end

  function automatic int exp_irqs(input int events, input int thr);
    return events / (thr + 1);
  endfunction

  function automatic int exp_thr_len(input int len, input int hold);
    return len + hold * CYC;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int len, input int gap);
    @(negedge clk);
    alarm_i = ~idle_lvl;
    repeat (len) @(negedge clk);
    alarm_i = idle_lvl;
    repeat (gap) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    int t0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 throttle after reset", int'(throttle_o), 0);
    check("R1 irq after reset", int'(irq_o), 0);
    rst = 1'b0;
    settle(3);
    check("R1 throttle idle", int'(throttle_o), 0);

    // R4 R11: threshold two, enable on, no filter, no hold
    wr(2'd1, 2);
    wr(2'd2, 0);
    wr(2'd3, 0);
    wr(2'd0, 1);
    base = irq_seen;
    pulse(3, 10); pulse(3, 10);
    check("R4 no irq before threshold", irq_seen - base, 0);
    pulse(3, 10);
    check("R4 irq on third event", irq_seen - base, 1);
    pulse(3, 10); pulse(3, 10); pulse(3, 10);
    check("R4 count restarts after irq", irq_seen - base, exp_irqs(6, 2));

    // R2: long pulses count once each
    base = irq_seen;
    pulse(30, 10); pulse(30, 10);
    check("R2 held alarm counted once", irq_seen - base, 0);
    pulse(3, 10);
    check("R2 third event fires", irq_seen - base, 1);

    // R10: zero hold follows alarm length
    t0 = thr_seen;
    pulse(5, 10);
    check("R10 throttle length zero hold", thr_seen - t0, exp_thr_len(5, 0));

    // R5: threshold zero
    wr(2'd1, 0);
    settle(2);
    base = irq_seen;
    for (int i = 0; i < 4; i++) pulse(2, 8);
    check("R5 irq every event", irq_seen - base, exp_irqs(4, 0));

    // R6: interrupts disabled
    wr(2'd0, 0);
    base = irq_seen;
    for (int i = 0; i < 3; i++) pulse(3, 8);
    check("R6 no irq when disabled", irq_seen - base, 0);

    // R7: filter clears count after quiet time
    wr(2'd2, 20);
    pulse(3, 40);
    wr(2'd1, 2);
    wr(2'd0, 1);
    base = irq_seen;
    for (int i = 0; i < 3; i++) pulse(3, 40);
    check("R7 spaced events cleared", irq_seen - base, 0);
    base = irq_seen;
    for (int i = 0; i < 9; i++) begin
      int len;
      int gap;
      len = 2 + int'($urandom_range(4));
      gap = 4 + int'($urandom_range(8));
      pulse(len, gap);
    end
    settle(6);
    check("R7 close events accumulate", irq_seen - base, exp_irqs(9, 2));

    // R8: filter zero keeps count over quiet time
    wr(2'd2, 0);
    base = irq_seen;
    for (int i = 0; i < 3; i++) pulse(3, 40);
    check("R8 no clear with zero filter", irq_seen - base, 1);

    // R9 R11: hold period in microseconds
    wr(2'd0, 0);
    for (int i = 0; i < 4; i++) begin
      int hold;
      int len;
      hold = 1 + int'($urandom_range(4));
      len  = 2 + int'($urandom_range(6));
      wr(2'd3, hold);
      settle(2);
      t0 = thr_seen;
      pulse(len, hold * CYC + 10);
      check("R9 R11 throttle length with hold", thr_seen - t0, exp_thr_len(len, hold));
    end

    // R3: active-low alarm
    wr(2'd3, 0);
    wr(2'd1, 0);
    base = irq_seen;
    wr(2'd0, 3);
    settle(5);
    check("R3 low line is active", int'(throttle_o), 1);
    idle_lvl = 1'b1;
    alarm_i = 1'b1;
    settle(6);
    check("R3 high line is idle", int'(throttle_o), 0);
    check("R3 polarity change no event", irq_seen - base, 0);
    t0 = thr_seen;
    pulse(4, 10); pulse(4, 10);
    check("R3 low pulses raise irq", irq_seen - base, 2);
    check("R3 low pulse throttle length", thr_seen - t0, 2 * exp_thr_len(4, 0));

    finish_run();
  end

endmodule